// File: doc/BRIEF.md
# Per-Core Power Domain Sequencer

This block switches a single processor core's power domain off or on by stepping through a fixed order of control actions. The actions are clamp isolation, the power-switch request, the power-good handshake and the core's power-on reset. After each control change that needs confirmation, the sequencer polls the matching status line from the power fabric, one attempt per clock, up to a bounded number of attempts. When the last attempt fails, the sequence either aborts with an error or carries on, depending on the step. Power-up has two fixed settle waits timed by a cycle counter. The first loads an 8-bit switch-finger field and waits. The second follows the power request.

Software or a boot controller starts a sequence with a one-cycle pulse. The pulse carries a direction and a core address given as a cluster number and a core-within-cluster number. A separate boot pulse walks the spare cores down one after another. Core 1 is always powered down. The second-cluster cores are powered down only when the part has two clusters. Completion is a one-cycle done or error pulse.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core has isolation off (0), power request on (1), power-good on (1) and reset released (1). The finger field is 0, and busy, done and error are 0.
- R2: A power-down request sets isolation and confirms it, then clears the power request and confirms it, then drops power-good, then asserts reset (control bit to 0) and confirms it. When every status follows its control at once, done rises 7 clocks after the edge that takes the start pulse.
- R3: A power-up request clears nothing until the settle waits are over. It loads the finger field, waits SETTLE cycles, raises the power request, waits SETTLE cycles, raises power-good and confirms it, clears isolation and confirms it, then releases reset and confirms it. With immediate status, done rises 8 + 2*SETTLE clocks after the start edge. SETTLE is CLK_MHZ*SETTLE_US.
- R4: Each confirmation makes at most POLL_LIMIT attempts, one per clock. A status that never arrives costs exactly POLL_LIMIT - 1 extra clocks over the immediate case.
- R5: During power-down, a missing isolation confirmation is tolerated and the sequence continues to done. A missing power-off or reset confirmation ends in error, and no later step is applied.
- R6: During power-up, a missing power-good or reset-release confirmation ends in error. A missing isolation-release confirmation is tolerated.
- R7: The target core is cluster*CORES_PER_CLUSTER + core. Only that core's controls change.
- R8: A boot pulse powers down core 1, then cores 2 and 3 unless the single-cluster input is 1. Core 0 is never touched, and done comes once at the end (23 clocks for three cores, 7 for one).
- R9: Start pulses are ignored while busy. A boot pulse wins over a start pulse that arrives in the same cycle.
- R10: Done and error last one clock, and the block is idle (busy 0) in the clock after.
- R11: With FINGER_PRELOAD set, power-up first writes 0xFC into the finger field, and the field keeps that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | One-cycle request for one core |
| dirUp | input | 1 | 1 = power up, 0 = power down |
| reqCluster | input | CLUSTER_W | Cluster number of the target core |
| reqCore | input | CORE_W | Core number within the cluster |
| bootStart | input | 1 | One-cycle request for the boot power-down walk |
| singleCluster | input | 1 | 1 = only the first cluster is present |
| isoStat | input | NUM_CORES | Isolation status per core, 1 = isolated |
| pwrStat | input | NUM_CORES | Power status per core, 1 = powered |
| rdyStat | input | NUM_CORES | Power-good status per core |
| rstStat | input | NUM_CORES | Reset status per core, 1 = released |
| isoEn | output | NUM_CORES | Isolation control per core |
| pwrOn | output | NUM_CORES | Power-switch request per core |
| pwrRdy | output | NUM_CORES | Power-good control per core |
| porRel | output | NUM_CORES | Reset release per core, 0 = held in reset |
| fingerField | output | FINGER_W | Power-switch finger setting |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle successful completion |
| error | output | 1 | One-cycle confirmation timeout abort |

## Verification
Every result has a fixed due cycle. It is 7 clocks for a clean power-down and 8 + 2*SETTLE for a clean power-up. A stalled confirmation adds POLL_LIMIT - 1 clocks, so a stalled power-off gives error at 2003 and a stalled power-good gives error at 2*SETTLE + 2003. The boot walk adds 8 clocks per extra core. The bench counts clock edges from the edge that captures the pulse and samples done and error on each falling edge. It compares the edge count with these figures, checks the control outputs at the completion edge, and checks one clock later that the block is idle.

// File: rtl/core_pwr_pkg.sv
`timescale 1ns/1ps
package core_pwr_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_FINGER, S_FINGER_WAIT,
    S_DN_ISO, S_DN_ISO_POLL, S_DN_PWR, S_DN_PWR_POLL, S_DN_RDY, S_DN_RST, S_DN_RST_POLL,
    S_UP_PWR, S_UP_WAIT, S_UP_RDY, S_UP_RDY_POLL, S_UP_ISO, S_UP_ISO_POLL, S_UP_RST, S_UP_RST_POLL,
    S_NEXT, S_FIN_OK, S_FIN_ERR
  } seqState_t;

  typedef struct packed {
    logic setIso;
    logic clrIso;
    logic setPwr;
    logic clrPwr;
    logic setRdy;
    logic clrRdy;
    logic relRst;
    logic asrtRst;
    logic loadFinger;
    logic clrCnt;
    logic incCnt;
    logic latchReq;
    logic bootLoad;
    logic bootAdvance;
  } seqStrobe_t;

endpackage

// File: rtl/core_pwr_dp.sv
`timescale 1ns/1ps
module core_pwr_dp
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES         = 4,
  parameter int CORES_PER_CLUSTER = 2,
  parameter int CLUSTER_W         = 1,
  parameter int CORE_W            = 1,
  parameter int IDX_W             = 2,
  parameter int CNT_W             = 13,
  parameter int FINGER_W          = 8,
  parameter logic [FINGER_W-1:0] FINGER_VALUE = 8'hFC
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [CLUSTER_W-1:0] reqCluster,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic                 singleCluster,
  input  logic [NUM_CORES-1:0] isoStat,
  input  logic [NUM_CORES-1:0] pwrStat,
  input  logic [NUM_CORES-1:0] rdyStat,
  input  logic [NUM_CORES-1:0] rstStat,
  output logic [NUM_CORES-1:0] isoEn,
  output logic [NUM_CORES-1:0] pwrOn,
  output logic [NUM_CORES-1:0] pwrRdy,
  output logic [NUM_CORES-1:0] porRel,
  output logic [FINGER_W-1:0]  fingerField,
  output logic [CNT_W-1:0]     cnt,
  output logic                 selIso,
  output logic                 selPwr,
  output logic                 selRdy,
  output logic                 selRst,
  output logic                 bootMore
);

  logic [IDX_W-1:0] coreIdx;
  logic [IDX_W-1:0] absIdx;
  logic             singleQ;
  logic [IDX_W:0]   nextIdx;
  logic [IDX_W:0]   bootLimit;

  // R7: absolute core number from cluster and core-in-cluster
  assign absIdx = IDX_W'(reqCluster) * IDX_W'(CORES_PER_CLUSTER) + IDX_W'(reqCore);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreIdx <= '0;
      singleQ <= 1'b0;
    end else if (strb.bootLoad) begin
      coreIdx <= IDX_W'(1);
      singleQ <= singleCluster;
    end else if (strb.bootAdvance) begin
      coreIdx <= coreIdx + IDX_W'(1);
    end else if (strb.latchReq) begin
      coreIdx <= absIdx;
    end
  end

  // R8: the walk stops at the end of the first cluster on single-cluster parts
  assign nextIdx   = {1'b0, coreIdx} + (IDX_W+1)'(1);
  assign bootLimit = singleQ ? (IDX_W+1)'(CORES_PER_CLUSTER) : (IDX_W+1)'(NUM_CORES);
  assign bootMore  = nextIdx < bootLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (strb.clrCnt)  cnt <= '0;
    else if (strb.incCnt)  cnt <= cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 fingerField <= '0;
    else if (strb.loadFinger)  fingerField <= FINGER_VALUE;
  end

  assign selIso = isoStat[coreIdx];
  assign selPwr = pwrStat[coreIdx];
  assign selRdy = rdyStat[coreIdx];
  assign selRst = rstStat[coreIdx];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    logic hit;
    assign hit = (coreIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        isoEn[i]  <= 1'b0;
        pwrOn[i]  <= 1'b1;
        pwrRdy[i] <= 1'b1;
        porRel[i] <= 1'b1;
      end else if (hit) begin
        if (strb.setIso)  isoEn[i]  <= 1'b1;
        if (strb.clrIso)  isoEn[i]  <= 1'b0;
        if (strb.setPwr)  pwrOn[i]  <= 1'b1;
        if (strb.clrPwr)  pwrOn[i]  <= 1'b0;
        if (strb.setRdy)  pwrRdy[i] <= 1'b1;
        if (strb.clrRdy)  pwrRdy[i] <= 1'b0;
        if (strb.relRst)  porRel[i] <= 1'b1;
        if (strb.asrtRst) porRel[i] <= 1'b0;
      end
    end

    // R2: power is removed only from an isolated core
    p_iso_before_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(pwrOn[i]) |-> isoEn[i]) else $error("R2 power removed without isolation");
    // R2: reset is asserted only after power-good has dropped
    p_rdy_before_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
      $fell(porRel[i]) |-> !pwrRdy[i]) else $error("R2 reset before power-good drop");
    // R3: power-good is raised only on a powered core
    p_pwr_before_rdy_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwrRdy[i]) |-> pwrOn[i]) else $error("R3 power-good without power");
    // R3: isolation released only once power-good is up
    p_rdy_before_unclamp_r3: assert property (@(posedge clk) disable iff (!rstN)
      $fell(isoEn[i]) |-> pwrRdy[i]) else $error("R3 isolation released early");
    // R3: reset released only after isolation is off
    p_unclamp_before_release_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(porRel[i]) |-> !isoEn[i]) else $error("R3 reset released while isolated");
  end

endmodule

// File: rtl/core_pwr_ctrl.sv
`timescale 1ns/1ps
module core_pwr_ctrl
  import core_pwr_pkg::*;
#(
  parameter int CNT_W          = 13,
  parameter int POLL_LIMIT     = 2000,
  parameter int SETTLE_CYCLES  = 5000,
  parameter bit FINGER_PRELOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             dirUp,
  input  logic             bootStart,
  input  logic             selIso,
  input  logic             selPwr,
  input  logic             selRdy,
  input  logic             selRst,
  input  logic             bootMore,
  input  logic [CNT_W-1:0] cnt,
  output seqStrobe_t       strb,
  output logic             busy,
  output logic             done,
  output logic             error
);

  seqState_t state, nxt;
  logic      bootMode, bootModeNxt;
  logic      pollLast, settleLast, inPoll;

  assign pollLast   = (cnt == CNT_W'(POLL_LIMIT - 1));
  assign settleLast = (cnt == CNT_W'(SETTLE_CYCLES - 1));
  assign inPoll     = (state == S_DN_ISO_POLL) || (state == S_DN_PWR_POLL) ||
                      (state == S_DN_RST_POLL) || (state == S_UP_RDY_POLL) ||
                      (state == S_UP_ISO_POLL) || (state == S_UP_RST_POLL);

  always_comb begin
    strb        = '0;
    nxt         = state;
    bootModeNxt = bootMode;
    unique case (state)
      S_IDLE: begin
        if (bootStart) begin              // R9: boot wins
          strb.bootLoad = 1'b1;
          bootModeNxt   = 1'b1;
          nxt           = S_DN_ISO;
        end else if (startPulse) begin
          strb.latchReq = 1'b1;
          bootModeNxt   = 1'b0;
          if (!dirUp)              nxt = S_DN_ISO;
          else if (FINGER_PRELOAD) nxt = S_FINGER;
          else                     nxt = S_UP_PWR;
        end
      end
      S_FINGER:      begin strb.loadFinger = 1'b1; strb.clrCnt = 1'b1; nxt = S_FINGER_WAIT; end
      S_FINGER_WAIT: begin strb.incCnt = 1'b1; if (settleLast) nxt = S_UP_PWR; end
      // power-down path
      S_DN_ISO:      begin strb.setIso = 1'b1; strb.clrCnt = 1'b1; nxt = S_DN_ISO_POLL; end
      S_DN_ISO_POLL: begin strb.incCnt = 1'b1; if (selIso || pollLast) nxt = S_DN_PWR; end
      S_DN_PWR:      begin strb.clrPwr = 1'b1; strb.clrCnt = 1'b1; nxt = S_DN_PWR_POLL; end
      S_DN_PWR_POLL: begin
        strb.incCnt = 1'b1;
        if (!selPwr)       nxt = S_DN_RDY;
        else if (pollLast) nxt = S_FIN_ERR;
      end
      S_DN_RDY:      begin strb.clrRdy = 1'b1; nxt = S_DN_RST; end
      S_DN_RST:      begin strb.asrtRst = 1'b1; strb.clrCnt = 1'b1; nxt = S_DN_RST_POLL; end
      S_DN_RST_POLL: begin
        strb.incCnt = 1'b1;
        if (!selRst)       nxt = (bootMode && bootMore) ? S_NEXT : S_FIN_OK;
        else if (pollLast) nxt = S_FIN_ERR;
      end
      S_NEXT:        begin strb.bootAdvance = 1'b1; nxt = S_DN_ISO; end
      // power-up path
      S_UP_PWR:      begin strb.setPwr = 1'b1; strb.clrCnt = 1'b1; nxt = S_UP_WAIT; end
      S_UP_WAIT:     begin strb.incCnt = 1'b1; if (settleLast) nxt = S_UP_RDY; end
      S_UP_RDY:      begin strb.setRdy = 1'b1; strb.clrCnt = 1'b1; nxt = S_UP_RDY_POLL; end
      S_UP_RDY_POLL: begin
        strb.incCnt = 1'b1;
        if (selRdy)        nxt = S_UP_ISO;
        else if (pollLast) nxt = S_FIN_ERR;
      end
      S_UP_ISO:      begin strb.clrIso = 1'b1; strb.clrCnt = 1'b1; nxt = S_UP_ISO_POLL; end
      S_UP_ISO_POLL: begin strb.incCnt = 1'b1; if (!selIso || pollLast) nxt = S_UP_RST; end
      S_UP_RST:      begin strb.relRst = 1'b1; strb.clrCnt = 1'b1; nxt = S_UP_RST_POLL; end
      S_UP_RST_POLL: begin
        strb.incCnt = 1'b1;
        if (selRst)        nxt = S_FIN_OK;
        else if (pollLast) nxt = S_FIN_ERR;
      end
      S_FIN_OK, S_FIN_ERR: nxt = S_IDLE;
      default:             nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      bootMode <= 1'b0;
    end else begin
      state    <= nxt;
      bootMode <= bootModeNxt;
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FIN_OK);
  assign error = (state == S_FIN_ERR);

  // R4: the attempt counter never passes the poll limit while confirming
  p_poll_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    inPoll |-> (cnt < CNT_W'(POLL_LIMIT))) else $error("R4 poll limit exceeded");
  // R10: completion pulses last one cycle and lead back to idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |=> !busy) else $error("R10 completion not followed by idle");
  // R9: a start pulse while busy does not disturb the running sequence
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !error) |=> busy) else $error("R9 sequence dropped early");

endmodule

// File: rtl/core_pwr_seq.sv
`timescale 1ns/1ps
module core_pwr_seq
  import core_pwr_pkg::*;
#(
  parameter int NUM_CORES         = 4,
  parameter int CORES_PER_CLUSTER = 2,
  parameter int CLK_MHZ           = 50,
  parameter int SETTLE_US         = 100,
  parameter int POLL_LIMIT        = 2000,
  parameter bit FINGER_PRELOAD    = 1'b1,
  parameter int FINGER_W          = 8,
  parameter logic [FINGER_W-1:0] FINGER_VALUE = 8'hFC,
  localparam int NUM_CLUSTERS  = NUM_CORES / CORES_PER_CLUSTER,
  localparam int CLUSTER_W     = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int CORE_W        = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startPulse,
  input  logic                 dirUp,
  input  logic [CLUSTER_W-1:0] reqCluster,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic                 bootStart,
  input  logic                 singleCluster,
  input  logic [NUM_CORES-1:0] isoStat,
  input  logic [NUM_CORES-1:0] pwrStat,
  input  logic [NUM_CORES-1:0] rdyStat,
  input  logic [NUM_CORES-1:0] rstStat,
  output logic [NUM_CORES-1:0] isoEn,
  output logic [NUM_CORES-1:0] pwrOn,
  output logic [NUM_CORES-1:0] pwrRdy,
  output logic [NUM_CORES-1:0] porRel,
  output logic [FINGER_W-1:0]  fingerField,
  output logic                 busy,
  output logic                 done,
  output logic                 error
);

  localparam int SETTLE_CYCLES = CLK_MHZ * SETTLE_US;
  localparam int CNT_MAX       = (SETTLE_CYCLES > POLL_LIMIT) ? SETTLE_CYCLES : POLL_LIMIT;
  localparam int CNT_W         = $clog2(CNT_MAX + 1);
  localparam int IDX_W         = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  seqStrobe_t       strb;
  logic [CNT_W-1:0] cnt;
  logic             selIso, selPwr, selRdy, selRst, bootMore;

  core_pwr_ctrl #(
    .CNT_W(CNT_W), .POLL_LIMIT(POLL_LIMIT),
    .SETTLE_CYCLES(SETTLE_CYCLES), .FINGER_PRELOAD(FINGER_PRELOAD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirUp(dirUp), .bootStart(bootStart),
    .selIso(selIso), .selPwr(selPwr), .selRdy(selRdy), .selRst(selRst),
    .bootMore(bootMore), .cnt(cnt), .strb(strb),
    .busy(busy), .done(done), .error(error)
  );

  core_pwr_dp #(
    .NUM_CORES(NUM_CORES), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .CLUSTER_W(CLUSTER_W), .CORE_W(CORE_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .FINGER_W(FINGER_W), .FINGER_VALUE(FINGER_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqCluster(reqCluster), .reqCore(reqCore),
    .singleCluster(singleCluster),
    .isoStat(isoStat), .pwrStat(pwrStat), .rdyStat(rdyStat), .rstStat(rstStat),
    .isoEn(isoEn), .pwrOn(pwrOn), .pwrRdy(pwrRdy), .porRel(porRel),
    .fingerField(fingerField), .cnt(cnt),
    .selIso(selIso), .selPwr(selPwr), .selRdy(selRdy), .selRst(selRst),
    .bootMore(bootMore)
  );

endmodule

// File: tb/core_pwr_seq_tb.sv
`timescale 1ns/1ps
module core_pwr_seq_tb;

  localparam int S       = 50 * 100;
  localparam int LAT_DN  = 7;
  localparam int LAT_UP  = 8 + 2 * S;
  localparam int XPOLL   = 2000 - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0, dirUp = 1'b0, bootStart = 1'b0, singleCluster = 1'b0;
  logic [0:0] reqCluster = '0;
  logic [0:0] reqCore = '0;
  logic [3:0] isoStat, pwrStat, rdyStat, rstStat;
  logic [3:0] isoEn, pwrOn, pwrRdy, porRel;
  logic [7:0] fingerField;
  logic busy, done, error;

  // status model: each status follows its control unless held
  logic [3:0] isoHold = '0, isoHoldV = '0, pwrHold = '0, pwrHoldV = '0;
  logic [3:0] rdyHold = '0, rdyHoldV = '0, rstHold = '0, rstHoldV = '0;
  assign isoStat = (isoEn  & ~isoHold) | (isoHoldV & isoHold);
  assign pwrStat = (pwrOn  & ~pwrHold) | (pwrHoldV & pwrHold);
  assign rdyStat = (pwrRdy & ~rdyHold) | (rdyHoldV & rdyHold);
  assign rstStat = (porRel & ~rstHold) | (rstHoldV & rstHold);

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  core_pwr_seq u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .dirUp(dirUp),
    .reqCluster(reqCluster), .reqCore(reqCore), .bootStart(bootStart),
    .singleCluster(singleCluster),
    .isoStat(isoStat), .pwrStat(pwrStat), .rdyStat(rdyStat), .rstStat(rstStat),
    .isoEn(isoEn), .pwrOn(pwrOn), .pwrRdy(pwrRdy), .porRel(porRel),
    .fingerField(fingerField), .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkVec(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic doReset();
    isoHold = '0; pwrHold = '0; rdyHold = '0; rstHold = '0;
    startPulse = 1'b0; bootStart = 1'b0;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runSeq(input bit boot, input bit alsoStart, input bit up,
                        input logic cl, input logic co, input bit single,
                        output int lat, output bit gotDone, output bit gotErr);
    @(negedge clk);
    bootStart = boot; startPulse = !boot || alsoStart;
    dirUp = up; reqCluster = cl; reqCore = co; singleCluster = single;
    @(negedge clk);
    bootStart = 1'b0; startPulse = 1'b0;
    lat = 0; gotDone = 1'b0; gotErr = 1'b0;
    while (lat < 40000 && !gotDone && !gotErr) begin
      @(negedge clk);
      lat++;
      gotDone = done;
      gotErr  = error;
    end
    chk(gotDone || gotErr, "R10 sequence never completed", 0, 1);
    @(negedge clk);
    chk(!done && !error && !busy, "R10 pulse one cycle then idle",
        {done, error, busy}, 0);
  endtask

  task automatic t_reset();
    doReset();
    chkVec("R1 isoEn reset",  isoEn, 4'h0);
    chkVec("R1 pwrOn reset",  pwrOn, 4'hF);
    chkVec("R1 pwrRdy reset", pwrRdy, 4'hF);
    chkVec("R1 porRel reset", porRel, 4'hF);
    chkVec("R1 finger reset", fingerField, 0);
    chkVec("R1 flags reset",  {busy, done, error}, 0);
  endtask

  task automatic t_down_up_core1();
    int lat; bit d, e;
    doReset();
    runSeq(0, 0, 0, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R2 down latency", lat, LAT_DN);
    chkVec("R2 down done", {d, e}, 2'b10);
    chkVec("R2 core1 iso", isoEn, 4'b0010);
    chkVec("R2 core1 pwr", pwrOn, 4'b1101);
    chkVec("R2 core1 rdy", pwrRdy, 4'b1101);
    chkVec("R2 core1 rst", porRel, 4'b1101);
    runSeq(0, 0, 1, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R3 up latency", lat, LAT_UP);
    chkVec("R3 up done", {d, e}, 2'b10);
    chkVec("R3 restored", {isoEn, pwrOn, pwrRdy, porRel}, 16'h0FFF);
    chkVec("R11 finger value", fingerField, 8'hFC);
  endtask

  task automatic t_index();
    int lat; bit d, e;
    doReset();
    runSeq(0, 0, 0, 1'b1, 1'b0, 0, lat, d, e);
    chkVec("R7 cluster1 core0 is core2 pwr", pwrOn, 4'b1011);
    chkVec("R7 cluster1 core0 is core2 iso", isoEn, 4'b0100);
    runSeq(0, 0, 0, 1'b1, 1'b1, 0, lat, d, e);
    chkVec("R7 cluster1 core1 is core3 rst", porRel, 4'b0011);
  endtask

  task automatic t_down_timeouts();
    int lat; bit d, e;
    doReset();
    isoHold = 4'b1000; isoHoldV = 4'b0000;
    runSeq(0, 0, 0, 1'b1, 1'b1, 0, lat, d, e);
    chkVec("R5 iso timeout tolerated", {d, e}, 2'b10);
    chkVec("R4 iso poll latency", lat, LAT_DN + XPOLL);
    chkVec("R5 core3 still powered off", {pwrOn[3], porRel[3]}, 0);
    doReset();
    pwrHold = 4'b0100; pwrHoldV = 4'b0100;
    runSeq(0, 0, 0, 1'b1, 1'b0, 0, lat, d, e);
    chkVec("R5 power-off timeout is error", {d, e}, 2'b01);
    chkVec("R4 power poll latency", lat, 3 + 2000);
    chkVec("R5 no later steps", {pwrRdy[2], porRel[2]}, 2'b11);
    doReset();
    rstHold = 4'b0010; rstHoldV = 4'b0010;
    runSeq(0, 0, 0, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R5 reset timeout is error", {d, e}, 2'b01);
  endtask

  task automatic t_up_timeouts();
    int lat; bit d, e;
    doReset();
    runSeq(0, 0, 0, 1'b0, 1'b1, 0, lat, d, e);
    rdyHold = 4'b0010; rdyHoldV = 4'b0000;
    runSeq(0, 0, 1, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R6 power-good timeout is error", {d, e}, 2'b01);
    chkVec("R6 power-good error latency", lat, 2 * S + 2003);
    chkVec("R6 isolation kept after error", {isoEn[1], porRel[1]}, 2'b10);
    doReset();
    runSeq(0, 0, 0, 1'b0, 1'b1, 0, lat, d, e);
    isoHold = 4'b0010; isoHoldV = 4'b0010;
    runSeq(0, 0, 1, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R6 iso release timeout ignored", {d, e}, 2'b10);
    chkVec("R6 iso release latency", lat, LAT_UP + XPOLL);
    chkVec("R6 reset released", porRel[1], 1);
    doReset();
    runSeq(0, 0, 0, 1'b0, 1'b1, 0, lat, d, e);
    rstHold = 4'b0010; rstHoldV = 4'b0000;
    runSeq(0, 0, 1, 1'b0, 1'b1, 0, lat, d, e);
    chkVec("R6 reset release timeout is error", {d, e}, 2'b01);
  endtask

  task automatic t_boot();
    int lat; bit d, e;
    doReset();
    runSeq(1, 1, 0, 1'b0, 1'b0, 0, lat, d, e);
    chkVec("R8 boot multi done", {d, e}, 2'b10);
    chkVec("R8 boot multi latency", lat, 23);
    chkVec("R8 cores 1-3 off, core0 on", pwrOn, 4'b0001);
    chkVec("R9 boot beats start, core0 reset released", porRel, 4'b0001);
    doReset();
    runSeq(1, 0, 0, 1'b0, 1'b0, 1, lat, d, e);
    chkVec("R8 boot single latency", lat, LAT_DN);
    chkVec("R8 boot single only core1", pwrOn, 4'b1101);
  endtask

  task automatic t_busy_ignore();
    int lat; bit sawDone;
    doReset();
    @(negedge clk);
    startPulse = 1'b1; dirUp = 1'b0; reqCluster = 1'b0; reqCore = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    @(negedge clk); @(negedge clk);
    startPulse = 1'b1; reqCluster = 1'b1; reqCore = 1'b0;
    @(negedge clk); startPulse = 1'b0;
    sawDone = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
    end
    chk(sawDone, "R9 first request completed", sawDone, 1);
    chkVec("R9 second request ignored", pwrOn, 4'b1101);
    chkVec("R9 idle after", busy, 0);
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    t_reset();
    t_down_up_core1();
    t_index();
    t_down_timeouts();
    t_up_timeouts();
    t_boot();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule